// File: doc/BRIEF.md
# Slave Port Grant Controller with Idle-Connection Policy

This block decides which of several bus masters owns one slave port of a multi-master interconnect. Masters raise request lines. The controller grants one of them, and holds that grant until the slave signals that the access has ended. When an access ends and no other permitted master is waiting, the controller does not simply drop the connection. It parks the slave according to a configurable idle policy: fully disconnected (for low power), kept on the master that used it last, or moved to a fixed master chosen by software. A master that finds the slave already parked on it starts its access with no arbitration delay. Any other master pays one arbitration cycle.

A static permission mask, set as a parameter for each slave instance, removes paths that must never exist. A master whose bit is clear is never granted, whatever it requests and whatever the configuration selects. A small configuration port writes the policy type and the fixed master index. A written value is used only while the slave is idle or at the moment an access ends, so it never disturbs a transfer in progress.

Top module: `dm_slave_arb`

## Requirements
- R1: After reset, `gnt_o` is all zero, `gnt_vld_o` and `act_o` are 0, and the idle policy is "none", so the slave stays disconnected while nothing is requested.
- R2: `gnt_o` is always one-hot or all zero. `gnt_vld_o` equals the OR of `gnt_o`. `act_o` is 1 only while a grant is present.
- R3: A master whose bit in the parameter `ALLOW` is 0 is never granted. Its request is ignored. A fixed index that points at such a master leaves the slave disconnected.
- R4: While idle, if permitted masters request and none of them is the currently connected master, the winner is granted on the next clock edge and `act_o` rises. The winner is chosen round-robin: the search starts at the index one above the most recently granted master and wraps. Before any grant, the search starts at master 0.
- R5: While `act_o` is 1 and `done_i` is 0, `gnt_o` and `act_o` hold.
- R6: When `done_i` is 1 during an access and another permitted master (not the holder) requests, the grant passes to the round-robin winner among those masters on the next edge, and `act_o` stays 1.
- R7: With policy code 2'b00 or 2'b11 (none), when an access ends with nothing else pending, or while idle with no request, the slave is disconnected on the next edge.
- R8: With policy code 2'b01 (last), at the idle point the slave stays connected to the most recently granted master. Before any grant, it is disconnected.
- R9: With policy code 2'b10 (fixed), at the idle point the slave connects to the master given by the configured fixed index.
- R10: While idle and connected, a request from the connected master raises `act_o` on the next edge with `gnt_o` unchanged, even if other masters also request.
- R11: `cfg_we_i` loads `cfg_type_i` and `cfg_idx_i` on the clock edge. A write during an access does not change `gnt_o` until that access ends. `done_i` has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Request line of each master |
| done_i | input | 1 | Current access ends this cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_type_i | input | 2 | Idle policy: 00 none, 01 last, 10 fixed, 11 none |
| cfg_idx_i | input | IDX_W | Fixed idle master index |
| gnt_o | output | N_MST | One-hot connection to a master, or zero |
| gnt_vld_o | output | 1 | A master is connected |
| act_o | output | 1 | The connected master owns an accepted access |

## Verification
Directed sequences first take a single master through each idle policy. These show whether the connection after `done_i` is dropped, kept or moved. Next come simultaneous requests from all masters, including the forbidden one, which separate the round-robin order, the handover at `done_i` and masking by the permission parameter. Requests from the parked master against requests from other masters, issued together and apart, separate the zero-latency path from the one-cycle arbitration path. Configuration writes landing mid-access against writes landing while idle show that the policy is only consulted at idle points. A long run of random requests, done strobes and writes, checked against a behavioural model every cycle, covers the remaining interleavings.

// File: rtl/dm_arb_pkg.sv
package dm_arb_pkg;
  typedef enum logic [1:0] {
    DM_NONE  = 2'b00,
    DM_LAST  = 2'b01,
    DM_FIXED = 2'b10,
    DM_RSVD  = 2'b11
  } dm_type_e;
endpackage

// File: rtl/dm_rr_pick.sv
module dm_rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             any_o,
  output logic [IDX_W-1:0] win_o
);
  int k;
  // descending offset: nearest index above last_i is assigned last and wins
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    k     = 0;
    for (int off = N; off >= 1; off--) begin
      k = (int'(last_i) + off) % N;
      if (req_i[k]) begin
        any_o = 1'b1;
        win_o = IDX_W'(k);
      end
    end
  end

  always_comb begin
    if (any_o) p_win_req_r4: assert (req_i[win_o]);
  end
endmodule

// File: rtl/dm_default_sel.sv
module dm_default_sel
  import dm_arb_pkg::*;
#(
  parameter int           N     = 4,
  parameter int           IDX_W = 2,
  parameter logic [N-1:0] ALLOW = '1
) (
  input  dm_type_e         type_i,
  input  logic [IDX_W-1:0] fix_idx_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             last_vld_i,
  output logic [N-1:0]     conn_o
);
  logic [N-1:0] raw;

  always_comb begin
    raw = '0;
    unique case (type_i)
      DM_LAST:  if (last_vld_i) raw[last_i] = 1'b1;
      DM_FIXED: raw[fix_idx_i] = 1'b1;
      default:  raw = '0;
    endcase
    conn_o = raw & ALLOW;
  end

  always_comb begin
    p_park_onehot_r2: assert ($onehot0(conn_o));
  end
endmodule

// File: rtl/dm_slave_arb.sv
module dm_slave_arb
  import dm_arb_pkg::*;
#(
  parameter int               N_MST = 4,
  parameter logic [N_MST-1:0] ALLOW = '1,
  localparam int              IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             done_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_type_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  output logic [N_MST-1:0] gnt_o,
  output logic             gnt_vld_o,
  output logic             act_o
);
  logic [N_MST-1:0] gnt_q, gnt_d, elig, pend, rr_req, park;
  logic             act_q, act_d, take;
  logic [IDX_W-1:0] last_q, fix_q, win;
  logic             last_vld_q, win_any;
  dm_type_e         type_q;

  assign elig = req_i & ALLOW;
  assign pend = elig & ~gnt_q;

  // idle with the parked master requesting: restrict pick to it (no re-arbitration)
  always_comb begin
    if (act_q)                rr_req = pend;
    else if (|(elig & gnt_q)) rr_req = elig & gnt_q;
    else                      rr_req = elig;
  end

  dm_rr_pick #(.N(N_MST), .IDX_W(IDX_W)) u_pick (
    .req_i  (rr_req),
    .last_i (last_q),
    .any_o  (win_any),
    .win_o  (win)
  );

  dm_default_sel #(.N(N_MST), .IDX_W(IDX_W), .ALLOW(ALLOW)) u_park (
    .type_i     (type_q),
    .fix_idx_i  (fix_q),
    .last_i     (last_q),
    .last_vld_i (last_vld_q),
    .conn_o     (park)
  );

  always_comb begin
    gnt_d = gnt_q;
    act_d = act_q;
    take  = 1'b0;
    if (act_q) begin
      if (done_i) begin
        if (win_any) take = 1'b1;
        else begin
          gnt_d = park;
          act_d = 1'b0;
        end
      end
    end else if (win_any) begin
      take = 1'b1;
    end else begin
      gnt_d = park;
    end
    if (take) begin
      gnt_d = N_MST'(1) << win;
      act_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q      <= '0;
      act_q      <= 1'b0;
      last_q     <= IDX_W'(N_MST - 1);
      last_vld_q <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
      act_q <= act_d;
      if (take) begin
        last_q     <= win;
        last_vld_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= DM_NONE;
      fix_q  <= '0;
    end else if (cfg_we_i) begin
      type_q <= dm_type_e'(cfg_type_i);
      fix_q  <= cfg_idx_i;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_vld_o = |gnt_q;
  assign act_o     = act_q;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_act_conn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> gnt_vld_o);
  p_no_forbid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~ALLOW) == '0);
  p_new_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_o && |(req_i & ALLOW) && !(|(req_i & ALLOW & gnt_o))) |=> (act_o && !$stable(gnt_o)));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !done_i) |=> (act_o && $stable(gnt_o)));
  p_handover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && done_i && |(req_i & ALLOW & ~gnt_o)) |=> (act_o && !$stable(gnt_o)));
  p_park_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && done_i && !(|(req_i & ALLOW & ~gnt_o)) && (type_q == DM_NONE || type_q == DM_RSVD))
    |=> (!gnt_vld_o && !act_o));
  p_park_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && done_i && !(|(req_i & ALLOW & ~gnt_o)) && type_q == DM_LAST)
    |=> ($stable(gnt_o) && !act_o));
  p_spec_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_o && |(req_i & gnt_o)) |=> (act_o && $stable(gnt_o)));
endmodule

// File: tb/dm_slave_arb_tb.sv
module dm_slave_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [N-1:0] ALW = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic done = 1'b0, we = 1'b0;
  logic [1:0] typ = 2'b00, idx = 2'b00;
  logic [N-1:0] gnt;
  logic gnt_vld, act;

  int n_chk = 0, n_fail = 0;
  int m_gnt = -1, m_last = N - 1, m_type = 0, m_idx = 0;
  bit m_act = 0, m_lvld = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dm_slave_arb #(.N_MST(N), .ALLOW(ALW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
    .cfg_we_i(we), .cfg_type_i(typ), .cfg_idx_i(idx),
    .gnt_o(gnt), .gnt_vld_o(gnt_vld), .act_o(act)
  );

  function automatic int rr(input logic [N-1:0] p, input int last);
    for (int off = 1; off <= N; off++) begin
      if (p[(last + off) % N]) return (last + off) % N;
    end
    return -1;
  endfunction

  function automatic int park();
    if (m_type == 1) return m_lvld ? m_last : -1;
    if (m_type == 2) return ALW[m_idx] ? m_idx : -1;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic d, input logic w,
                      input logic [1:0] t, input logic [1:0] ix, input string tag);
    logic [N-1:0] el, pd, eg;
    int nw;
    @(negedge clk);
    req = r; done = d; we = w; typ = t; idx = ix;
    el = r & ALW;
    if (m_act) begin
      if (d) begin
        pd = el & ~(N'(1) << m_gnt);
        nw = rr(pd, m_last);
        if (nw >= 0) begin m_gnt = nw; m_last = nw; m_lvld = 1; end
        else begin m_gnt = park(); m_act = 0; end
      end
    end else if (m_gnt >= 0 && el[m_gnt]) begin
      m_act = 1; m_last = m_gnt; m_lvld = 1;
    end else begin
      nw = rr(el, m_last);
      if (nw >= 0) begin m_gnt = nw; m_last = nw; m_lvld = 1; m_act = 1; end
      else m_gnt = park();
    end
    if (w) begin m_type = int'(t); m_idx = int'(ix); end
    @(posedge clk); #1;
    eg = (m_gnt >= 0) ? (N'(1) << m_gnt) : '0;
    chk(gnt == eg, tag, int'(gnt), int'(eg));
    chk(act == m_act, tag, int'(act), int'(m_act));
    chk($onehot0(gnt) && gnt_vld == |gnt && (!act || gnt_vld), "R2", int'(gnt), int'(gnt_vld));
    chk((gnt & ~ALW) == '0, "R3", int'(gnt), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(gnt == '0 && !gnt_vld && !act, "R1", int'({gnt, gnt_vld, act}), 0);
    step('0, 0, 0, 0, 0, "R1");
    step('0, 1, 0, 0, 0, "R11");            // done while idle ignored
    // none policy, single master
    step(4'b0010, 0, 0, 0, 0, "R4");
    step(4'b0010, 0, 0, 0, 0, "R5");
    step(4'b0000, 0, 0, 0, 0, "R5");
    step(4'b0000, 1, 0, 0, 0, "R7");
    step('0, 0, 0, 0, 0, "R7");
    // round robin from last=1, forbidden master 3 also requests
    step(4'b1111, 0, 0, 0, 0, "R4");        // -> 2
    step(4'b1011, 1, 0, 0, 0, "R6");        // handover -> 0
    step(4'b1010, 1, 0, 0, 0, "R6");        // -> 1
    step(4'b1000, 1, 0, 0, 0, "R3");        // only forbidden pending -> drop
    step(4'b1000, 0, 0, 0, 0, "R3");
    // last policy
    step('0, 0, 1, 2'b01, 0, "R8");
    step(4'b0100, 0, 0, 2'b01, 0, "R4");
    step(4'b0000, 1, 0, 2'b01, 0, "R8");
    step('0, 0, 0, 2'b01, 0, "R8");
    step(4'b0101, 0, 0, 2'b01, 0, "R10");   // parked master 2 wins at once
    step('0, 1, 0, 2'b01, 0, "R8");
    step(4'b0001, 0, 0, 2'b01, 0, "R4");    // other master: one cycle
    step('0, 1, 0, 2'b01, 0, "R8");
    // fixed policy, written mid-access
    step(4'b0010, 0, 0, 0, 0, "R4");
    step(4'b0010, 0, 1, 2'b10, 2'd2, "R11");
    step('0, 0, 0, 0, 0, "R11");
    step('0, 1, 0, 0, 0, "R9");
    step('0, 0, 0, 0, 0, "R9");
    step(4'b0100, 0, 0, 0, 0, "R10");
    step('0, 1, 0, 0, 0, "R9");
    step('0, 0, 1, 2'b10, 2'd3, "R3");      // fixed at forbidden
    step('0, 0, 0, 0, 0, "R3");
    step('0, 0, 1, 2'b11, 2'd1, "R7");      // reserved code = none
    step('0, 0, 0, 0, 0, "R7");
    // random interleavings
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      logic d, w;
      r = N'($urandom);
      d = ($urandom % 3) == 0;
      w = ($urandom % 8) == 0;
      step(r, d, w, 2'($urandom), 2'($urandom), "R6");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule